// File: doc/BRIEF.md
# Instruction-Count Interrupt Scheduler

This block produces periodic interrupt requests for a small 8-bit processor core. It does not watch external pins. Instead it counts the instructions the core retires. There are two sources, one non-maskable and one maskable. Each source has a programmable period and its own down-counter. Each time a source's period worth of instructions has retired, that source becomes pending.

The scheduler chooses which pending source to present, following these rules:

- The non-maskable source always wins.
- The non-maskable source may nest over any service routine already running.
- The maskable source is presented only when the core's mask flag is clear and no service routine is active. Until then it waits.

The block outputs a registered request, a bit that tells which source it is, and the vector address the core should fetch. It also keeps a nesting depth. The depth rises when the core acknowledges entry into a routine and falls on each return-from-interrupt strobe. Saving and restoring registers on the stack is left to the core.

Top module: `irq_tick_sched`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `req_o` and `req_nmi_o` are 0, `vec_o` is 0 and `depth_o` is 0. Both periods reset to 0, so both sources start disabled.
- R2: After a period N (N ≥ 1) is written, a source becomes pending on exactly every N-th retire strobe. The counter then reloads from the period, so the interrupts repeat. The request is visible on the outputs right after the clock edge that registers the N-th retire.
- R3: A period of 0 disables its source: no retire strobe makes it pending.
- R4: A write (`wr_en_i` high, `wr_sel_i` = 0 for the non-maskable source, 1 for the maskable one) loads both the period and the counter of the selected source. If a retire strobe arrives in the same cycle, the write takes precedence and the strobe is not counted for that source.
- R5: When the non-maskable source is pending, it is presented (`req_o` = 1, `req_nmi_o` = 1) whatever the state of the maskable source.
- R6: The maskable request is presented only if `imask_i` was 0 in the cycle that produced it. While the mask is set, a pending maskable interrupt is held back, not lost.
- R7: The maskable request is never presented while `depth_o` is nonzero. A maskable interrupt that comes due during a routine stays pending and is presented in the cycle after the depth returns to 0.
- R8: The non-maskable request is presented even while `depth_o` is nonzero, so routines may nest.
- R9: While a request is presented, `vec_o` is 0xFFFC for the non-maskable source and 0xFFF8 for the maskable one. Otherwise `vec_o` is 0.
- R10: `ack_i` with `req_o` high increments `depth_o`; `rti_i` decrements it. If both come in the same cycle, the depth is unchanged. The depth saturates at 2^DW−1 and at 0. `ack_i` while `req_o` is low has no effect.
- R11: An acknowledge clears the pending flag of the source that was presented. If that source comes due again in the same cycle, its flag stays set and it is presented again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_i | input | 1 | One instruction retired this cycle |
| imask_i | input | 1 | Core interrupt-mask flag (1 = maskable source blocked) |
| ack_i | input | 1 | Core enters the presented service routine |
| rti_i | input | 1 | Core returned from a service routine |
| wr_en_i | input | 1 | Period write strobe |
| wr_sel_i | input | 1 | Period select: 0 non-maskable, 1 maskable |
| wr_data_i | input | CW | New period value (0 disables) |
| req_o | output | 1 | Interrupt request presented |
| req_nmi_o | output | 1 | Presented request is the non-maskable one |
| vec_o | output | AW | Vector address of the presented request |
| depth_o | output | DW | Current service-routine nesting depth |

## Verification
The hardest situations to reach from the ports are the ones where several events land on the same clock edge:

- a maskable interrupt that comes due while a routine is running, and so must survive until the final return;
- an expiry that coincides with the acknowledge of the same source;
- both sources expiring together.

The stimulus reaches these with short periods (1 to 5 instructions) and by timing the acknowledge and return strobes against the known count. Saturation needs a period of 1 with an acknowledge on every retire, which stacks nested non-maskable entries until the depth counter is full. A long randomised run then mixes mask toggles, rewrites and strobes. A behavioural model is compared with the design every cycle.

// File: rtl/isched_pkg.sv
package isched_pkg;

  localparam int unsigned NUM_SRC = 2;
  localparam int unsigned SRC_NMI = 0;
  localparam int unsigned SRC_IRQ = 1;

  typedef struct packed {
    logic valid;
    logic is_nmi;
  } grant_t;

endpackage

// File: rtl/isched_counter.sv
module isched_counter #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          tick_i,
  output logic          expire_o
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] period_q;
  logic [CW-1:0] count_q;
  logic          enabled;
  logic          last;

  assign enabled  = (period_q != '0);
  assign last     = (count_q <= ONE);
  assign expire_o = tick_i && !load_i && enabled && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= '0;
      count_q  <= '0;
    end else if (load_i) begin
      period_q <= load_val_i;
      count_q  <= load_val_i;
    end else if (tick_i && enabled) begin
      if (last) count_q <= period_q;
      else      count_q <= count_q - ONE;
    end
  end

endmodule

// File: rtl/isched_arbiter.sv
module isched_arbiter
  import isched_pkg::*;
(
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic               mask_i,
  input  logic               idle_i,
  output grant_t             grant_o
);

  always_comb begin
    grant_o = '0;
    if (pend_i[SRC_NMI]) begin
      grant_o.valid  = 1'b1;
      grant_o.is_nmi = 1'b1;
    end else if (pend_i[SRC_IRQ] && !mask_i && idle_i) begin
      grant_o.valid  = 1'b1;
      grant_o.is_nmi = 1'b0;
    end
  end

endmodule

// File: rtl/isched_depth.sv
module isched_depth #(
  parameter int unsigned DW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc_i,
  input  logic          dec_i,
  output logic [DW-1:0] depth_nxt_o,
  output logic [DW-1:0] depth_o
);

  localparam logic [DW-1:0] FULL = {DW{1'b1}};
  localparam logic [DW-1:0] STEP = DW'(1);

  logic [DW-1:0] depth_q;

  always_comb begin
    depth_nxt_o = depth_q;
    if (inc_i && !dec_i && depth_q != FULL)
      depth_nxt_o = depth_q + STEP;
    else if (dec_i && !inc_i && depth_q != '0)
      depth_nxt_o = depth_q - STEP;
  end

  always_ff @(posedge clk) begin
    if (rst) depth_q <= '0;
    else     depth_q <= depth_nxt_o;
  end

  assign depth_o = depth_q;

endmodule

// File: rtl/irq_tick_sched.sv
module irq_tick_sched
  import isched_pkg::*;
#(
  parameter int unsigned    CW      = 16,
  parameter int unsigned    DW      = 3,
  parameter int unsigned    AW      = 16,
  parameter logic [AW-1:0]  NMI_VEC = 16'hFFFC,
  parameter logic [AW-1:0]  IRQ_VEC = 16'hFFF8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          retire_i,
  input  logic          imask_i,
  input  logic          ack_i,
  input  logic          rti_i,
  input  logic          wr_en_i,
  input  logic          wr_sel_i,
  input  logic [CW-1:0] wr_data_i,
  output logic          req_o,
  output logic          req_nmi_o,
  output logic [AW-1:0] vec_o,
  output logic [DW-1:0] depth_o
);

  logic [NUM_SRC-1:0] expire;
  logic [NUM_SRC-1:0] clr;
  logic [NUM_SRC-1:0] pend_nxt;
  logic [NUM_SRC-1:0] pend_q;
  logic               req_q;
  logic               nmi_q;
  logic [AW-1:0]      vec_q;
  logic               took;
  logic [DW-1:0]      depth_nxt;
  grant_t             grant;

  assign took = ack_i && req_q;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    localparam logic SEL = (s == SRC_IRQ);
    localparam logic IS_NMI = (s == SRC_NMI);

    isched_counter #(.CW(CW)) u_cnt (
      .clk        (clk),
      .rst        (rst),
      .load_i     (wr_en_i && (wr_sel_i == SEL)),
      .load_val_i (wr_data_i),
      .tick_i     (retire_i),
      .expire_o   (expire[s])
    );

    assign clr[s]      = took && (nmi_q == IS_NMI);
    assign pend_nxt[s] = expire[s] || (pend_q[s] && !clr[s]);

    always_ff @(posedge clk) begin
      if (rst) pend_q[s] <= 1'b0;
      else     pend_q[s] <= pend_nxt[s];
    end
  end

  isched_depth #(.DW(DW)) u_depth (
    .clk         (clk),
    .rst         (rst),
    .inc_i       (took),
    .dec_i       (rti_i),
    .depth_nxt_o (depth_nxt),
    .depth_o     (depth_o)
  );

  isched_arbiter u_arb (
    .pend_i  (pend_nxt),
    .mask_i  (imask_i),
    .idle_i  (depth_nxt == '0),
    .grant_o (grant)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      nmi_q <= 1'b0;
      vec_q <= '0;
    end else begin
      req_q <= grant.valid;
      nmi_q <= grant.valid && grant.is_nmi;
      if (!grant.valid)     vec_q <= '0;
      else if (grant.is_nmi) vec_q <= NMI_VEC;
      else                  vec_q <= IRQ_VEC;
    end
  end

  assign req_o     = req_q;
  assign req_nmi_o = nmi_q;
  assign vec_o     = vec_q;

endmodule

// File: rtl/isched_checker.sv
module isched_checker #(
  parameter int unsigned   DW      = 3,
  parameter int unsigned   AW      = 16,
  parameter logic [AW-1:0] NMI_VEC = 16'hFFFC,
  parameter logic [AW-1:0] IRQ_VEC = 16'hFFF8
) (
  input logic          clk,
  input logic          rst,
  input logic          imask_i,
  input logic          ack_i,
  input logic          rti_i,
  input logic          req_o,
  input logic          req_nmi_o,
  input logic [AW-1:0] vec_o,
  input logic [DW-1:0] depth_o,
  input logic          pend_nmi
);

  p_quiet_after_reset_r1: assert property (@(posedge clk)
    rst |=> (!req_o && !req_nmi_o && depth_o == '0));

  p_nmi_first_r5: assert property (@(posedge clk) disable iff (rst)
    pend_nmi |-> (req_o && req_nmi_o));

  p_irq_unmasked_r6: assert property (@(posedge clk) disable iff (rst)
    (req_o && !req_nmi_o) |-> !$past(imask_i));

  p_irq_idle_only_r7: assert property (@(posedge clk) disable iff (rst)
    (req_o && !req_nmi_o) |-> (depth_o == '0));

  p_vector_r9: assert property (@(posedge clk) disable iff (rst)
    vec_o == (!req_o ? '0 : (req_nmi_o ? NMI_VEC : IRQ_VEC)));

  p_depth_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!ack_i && !rti_i) |=> $stable(depth_o));

  p_depth_down_r10: assert property (@(posedge clk) disable iff (rst)
    (rti_i && !ack_i && depth_o != '0) |=> (depth_o == DW'($past(depth_o) - 1'b1)));

endmodule

bind irq_tick_sched isched_checker #(
  .DW(DW), .AW(AW), .NMI_VEC(NMI_VEC), .IRQ_VEC(IRQ_VEC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .imask_i   (imask_i),
  .ack_i     (ack_i),
  .rti_i     (rti_i),
  .req_o     (req_o),
  .req_nmi_o (req_nmi_o),
  .vec_o     (vec_o),
  .depth_o   (depth_o),
  .pend_nmi  (pend_q[0])
);

// File: tb/sim_irq_tick_sched.sv
`timescale 1ns/100ps
module sim_irq_tick_sched;

  localparam int DMAX = 7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        retire = 1'b0, imask = 1'b0, ack = 1'b0, rti = 1'b0;
  logic        wr = 1'b0, sel = 1'b0;
  logic [15:0] wdata = '0;
  logic        req_o, req_nmi_o;
  logic [15:0] vec_o;
  logic [2:0]  depth_o;

  int    checks = 0;
  int    fails  = 0;
  string phase  = "R1";

  always #2.5 clk = ~clk;

  irq_tick_sched u0 (
    .clk(clk), .rst(rst), .retire_i(retire), .imask_i(imask), .ack_i(ack),
    .rti_i(rti), .wr_en_i(wr), .wr_sel_i(sel), .wr_data_i(wdata),
    .req_o(req_o), .req_nmi_o(req_nmi_o), .vec_o(vec_o), .depth_o(depth_o)
  );

  // behavioural reference
  int m_per[2];
  int m_cnt[2];
  bit m_pend[2];
  int m_depth;
  bit m_req, m_nmi, armed;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_per[i]) begin m_per[i] = 0; m_cnt[i] = 0; m_pend[i] = 0; end
      m_depth = 0; m_req = 0; m_nmi = 0;
    end else begin
      bit took;
      took = ack && m_req;
      for (int s = 0; s < 2; s++) begin
        bit e, clr;
        e = 0;
        if (wr && int'(sel) == s) begin
          m_per[s] = int'(wdata); m_cnt[s] = int'(wdata);
        end else if (retire && m_per[s] != 0) begin
          if (m_cnt[s] <= 1) begin m_cnt[s] = m_per[s]; e = 1; end
          else m_cnt[s]--;
        end
        clr = took && ((s == 0) ? m_nmi : !m_nmi);
        m_pend[s] = e || (m_pend[s] && !clr);
      end
      if (took && !rti && m_depth < DMAX) m_depth++;
      else if (rti && !took && m_depth > 0) m_depth--;
      if (m_pend[0]) begin m_req = 1; m_nmi = 1; end
      else if (m_pend[1] && !imask && m_depth == 0) begin m_req = 1; m_nmi = 0; end
      else begin m_req = 0; m_nmi = 0; end
    end
    armed = 1;
  end

  always @(negedge clk) begin
    if (armed) begin
      int ev;
      ev = !m_req ? 0 : (m_nmi ? 16'hFFFC : 16'hFFF8);
      checks++;
      if (req_o !== m_req || req_nmi_o !== m_nmi || int'(vec_o) != ev ||
          int'(depth_o) != m_depth) begin
        fails++;
        $display("FAIL %s: cycle compare actual req=%b nmi=%b vec=%h depth=%0d expected req=%b nmi=%b vec=%h depth=%0d",
                 phase, req_o, req_nmi_o, vec_o, depth_o, m_req, m_nmi, ev[15:0], m_depth);
      end
    end
  end

  task automatic chk(input bit c, input string tag, input int act, input int exp);
    checks++;
    if (!c) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic a, input logic t,
                      input logic w, input logic s, input logic [15:0] d);
    retire = r; ack = a; rti = t; wr = w; sel = s; wdata = d;
    @(negedge clk);
    retire = 0; ack = 0; rti = 0; wr = 0; sel = 0; wdata = '0;
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 16'h0); endtask
  task automatic retire1(); step(1, 0, 0, 0, 0, 16'h0); endtask
  task automatic take(); step(0, 1, 0, 0, 0, 16'h0); endtask
  task automatic ret(); step(0, 0, 1, 0, 0, 16'h0); endtask
  task automatic setp(input logic s, input logic [15:0] d); step(0, 0, 0, 1, s, d); endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(req_o == 0 && depth_o == 0 && vec_o == 0, "R1 reset outputs", int'(req_o), 0);
    rst = 0;
    idle();
    chk(req_o == 0 && depth_o == 0, "R1 after release", int'(req_o), 0);

    // R2: NMI every 4096 retires
    phase = "R2";
    setp(0, 16'h1000);
    n = 0;
    for (int i = 0; i < 8192; i++) begin
      logic a;
      a = req_o;
      if (a && req_nmi_o) n++;
      step(1, a, 0, 0, 0, 16'h0);
    end
    if (req_o && req_nmi_o) begin n++; take(); end
    chk(n == 2, "R2 NMI count over 8192 retires", n, 2);
    setp(0, 16'h0);
    repeat (3) ret();

    // R2/R6: IRQ every 512 retires with mask clear
    setp(1, 16'h0200);
    n = 0;
    for (int i = 0; i < 1536; i++) begin
      logic a;
      a = req_o && !req_nmi_o;
      step(1, a, 0, 0, 0, 16'h0);
      if (a) begin n++; ret(); end
    end
    if (req_o && !req_nmi_o) begin n++; take(); ret(); end
    chk(n == 3, "R2 IRQ count over 1536 retires", n, 3);
    setp(1, 16'h0);

    // R3: period zero disables
    phase = "R3";
    repeat (600) retire1();
    chk(req_o == 0, "R3 disabled sources stay quiet", int'(req_o), 0);

    // R4: write restarts counter and beats retire
    phase = "R4";
    setp(1, 16'd5);
    repeat (3) retire1();
    step(1, 0, 0, 1, 1, 16'd5);
    repeat (4) retire1();
    chk(req_o == 0, "R4 no request before restarted period", int'(req_o), 0);
    retire1();
    chk(req_o == 1 && req_nmi_o == 0, "R4 request at restarted period", int'(req_o), 1);
    take(); ret();
    setp(1, 16'h0);

    // R6: mask holds IRQ pending
    phase = "R6";
    imask = 1;
    setp(1, 16'd3);
    repeat (3) retire1();
    chk(req_o == 0, "R6 masked IRQ not presented", int'(req_o), 0);
    setp(1, 16'h0);
    imask = 0;
    idle();
    chk(req_o == 1 && req_nmi_o == 0, "R6 IRQ presented once mask clears", int'(req_o), 1);
    take(); ret();

    // R7: IRQ blocked during routine, kept pending
    phase = "R7";
    setp(1, 16'd2);
    repeat (2) retire1();
    take();
    chk(depth_o == 1, "R7 depth after entry", int'(depth_o), 1);
    repeat (2) retire1();
    chk(req_o == 0, "R7 IRQ held while routine active", int'(req_o), 0);
    ret();
    chk(req_o == 1 && req_nmi_o == 0, "R7 IRQ after return", int'(req_o), 1);
    take(); ret();
    setp(1, 16'h0);

    // R5/R9: simultaneous expiry, NMI first
    phase = "R5";
    setp(0, 16'd4);
    setp(1, 16'd4);
    repeat (4) retire1();
    chk(req_o == 1 && req_nmi_o == 1, "R5 NMI wins", int'(req_nmi_o), 1);
    chk(vec_o == 16'hFFFC, "R9 NMI vector", int'(vec_o), 16'hFFFC);
    take();
    chk(req_o == 0, "R7 IRQ blocked under NMI routine", int'(req_o), 0);
    ret();
    chk(req_o == 1 && req_nmi_o == 0, "R5 IRQ after NMI", int'(req_o), 1);
    chk(vec_o == 16'hFFF8, "R9 IRQ vector", int'(vec_o), 16'hFFF8);
    take(); ret();
    setp(0, 16'h0);
    setp(1, 16'h0);

    // R8/R10: nesting to saturation
    phase = "R8";
    setp(0, 16'd1);
    retire1();
    for (int i = 0; i < 9; i++) begin
      chk(req_o == 1 && req_nmi_o == 1, "R8 NMI during routine", int'(req_o), 1);
      step(1, req_o, 0, 0, 0, 16'h0);
    end
    chk(depth_o == 7, "R10 depth saturates", int'(depth_o), 7);
    setp(0, 16'h0);
    take();
    phase = "R10";
    repeat (9) ret();
    chk(depth_o == 0, "R10 depth floors at zero", int'(depth_o), 0);
    take();
    chk(depth_o == 0, "R10 ack without request ignored", int'(depth_o), 0);

    // R11: re-expiry in same cycle as ack
    phase = "R11";
    setp(0, 16'd1);
    retire1();
    step(1, 1, 0, 0, 0, 16'h0);
    chk(req_o == 1 && req_nmi_o == 1, "R11 NMI re-presented", int'(req_o), 1);
    chk(depth_o == 1, "R11 depth after ack", int'(depth_o), 1);
    setp(0, 16'h0);
    take();
    repeat (2) ret();
    chk(req_o == 0 && depth_o == 0, "R11 drained", int'(req_o), 0);

    // random mix against the reference
    phase = "R9";
    setp(0, 16'd7);
    setp(1, 16'd3);
    for (int i = 0; i < 3000; i++) begin
      logic r, a, t, w;
      r = ($urandom_range(0, 9) < 7);
      a = req_o && ($urandom_range(0, 1) == 1);
      t = ($urandom_range(0, 4) == 0);
      w = ($urandom_range(0, 49) == 0);
      if ($urandom_range(0, 9) == 0) imask = ~imask;
      step(r, a, t, w, logic'($urandom_range(0, 1)), 16'($urandom_range(0, 9)));
    end

    summary();
    $finish;
  end

endmodule